// File: doc/BRIEF.md
# External Interrupt Port Source Multiplexer

This block chooses, for each of sixteen external interrupt lines, which of eleven GPIO ports feeds that line. Line x always carries pin x of the chosen port. The choice for each line is a 4-bit select code. Four 32-bit configuration registers on a simple memory-mapped bus hold these codes. Downstream logic (edge detectors, masks, pending flags) sees the sixteen routed lines and nothing else.

Software writes a register to change the source of four lines at once, and can read the register back. Some codes are reserved. The last port has only its lower eight pins. A line that is set to a reserved code, or to a pin that does not exist, is held low. The routing path is combinational from the stored codes and the pin inputs. A new code therefore takes effect in the cycle that follows the write.

Top module: `irq_port_route`

## Requirements
- R1: After reset all select codes are 0. Every line x then follows pin x of port 0, and the read data output is 0.
- R2: A write changes only the register whose byte offset equals the bus address exactly. Register n sits at offset 0x08 + 4*n for n = 0..3. A write to any other address, including an unaligned one such as 0x09, changes no register.
- R3: Line 4*n + k takes its code from bits [4k+3:4k] of register n.
- R4: Code c, from 0 to 10, routes pin x of port c to line x. Port c occupies bits [16c+15:16c] of the pin input vector.
- R5: Codes 11 to 15 drive the line to 0 whatever the pin inputs are.
- R6: Code 10 (port K) drives lines 8 to 15 to 0, because that port has no pins 8 to 15. Lines 0 to 7 follow port K normally.
- R7: Bits 31:16 of each select register always read 0, and writes to them have no effect.
- R8: When a read is accepted in a cycle, the read data output holds the addressed register after that clock edge. An address that is not a select register reads 0. When no read is accepted, the read data output keeps its value.
- R9: A written code changes the routed lines in the cycle after the write. A change on the pin inputs reaches the lines in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| port_pins | input | 176 | Eleven 16-bit port pin vectors, port c in bits [16c+15:16c] |
| irq_line | output | 16 | Routed interrupt lines |

## Verification
Each register is written first with one code repeated in every field, for every legal code. This shows that each port reaches all sixteen lines, and it exposes a port-index or pin-index mix-up. Per-line codes that differ, combined with walking single pins, separate the field position of each line from its neighbours. Reserved codes and port K on the upper lines are driven with the pins all high, so any leak shows up as a 1. Writes to stray or unaligned addresses, writes that set the upper halves, and reads from unmapped offsets confirm that nothing outside the four exact fields is stored. Pins that toggle every cycle after a write confirm that routing is combinational and that a new code takes effect one cycle after the write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int FIELD_W   = 4;
  localparam int REG_BYTES = 4;

  // A line can be driven only by a port that exists, and only by a pin that exists on it.
  function automatic logic code_routable(input logic [FIELD_W-1:0] code,
                                         input int line, input int ports,
                                         input int last_pins);
    if (int'(code) >= ports) return 1'b0;
    if (int'(code) == ports - 1 && line >= last_pins) return 1'b0;
    return 1'b1;
  endfunction

  // Byte offset of select register n.
  function automatic int reg_offset(input int base, input int n);
    return base + REG_BYTES * n;
  endfunction
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
  import irq_route_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int REGS     = 4,
  parameter int PER_REG  = 4,
  parameter int BASE_OFF = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_en,
  input  logic                             bus_wr,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  output logic [REGS*PER_REG*FIELD_W-1:0]  sel_flat
);
  localparam int FBITS = PER_REG * FIELD_W;

  logic [FBITS-1:0]  sel_q [REGS];
  logic [REGS-1:0]   addr_hit;
  logic [REGS-1:0]   wr_hit;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  assign rd_fire      = bus_en & ~bus_wr;
  assign unused_wdata = ^bus_wdata[DATA_W-1:FBITS];

  genvar r;
  generate
    for (r = 0; r < REGS; r++) begin : g_reg
      assign addr_hit[r] = (bus_addr == ADDR_W'(reg_offset(BASE_OFF, r)));
      assign wr_hit[r]   = bus_en & bus_wr & addr_hit[r];
      assign sel_flat[r*FBITS +: FBITS] = sel_q[r];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_q[r] <= '0;
        else if (wr_hit[r]) sel_q[r] <= bus_wdata[FBITS-1:0];
      end

      // R2: a register moves only when its own offset is written
      p_hold_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[r] |=> $stable(sel_q[r]));
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < REGS; i++)
      if (addr_hit[i]) rd_next = DATA_W'(sel_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (rd_fire) bus_rdata <= rd_next;
  end

  // R8: read data holds when no read is accepted
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(bus_rdata));
  // R7: upper half of any read is zero
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:FBITS] == '0);
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
  import irq_route_pkg::*;
#(
  parameter int LINES     = 16,
  parameter int PORTS     = 11,
  parameter int PINS      = 16,
  parameter int LAST_PINS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES*FIELD_W-1:0] sel_flat,
  input  logic [PORTS*PINS-1:0]    port_pins,
  output logic [LINES-1:0]         irq_line
);
  logic [LINES-1:0] line_ok;
  logic [LINES-1:0] line_pick;

  genvar x;
  generate
    for (x = 0; x < LINES; x++) begin : g_line
      logic [FIELD_W-1:0] code;
      assign code       = sel_flat[x*FIELD_W +: FIELD_W];
      assign line_ok[x] = code_routable(code, x, PORTS, LAST_PINS);

      always_comb begin
        line_pick[x] = 1'b0;
        for (int p = 0; p < PORTS; p++)
          if (int'(code) == p) line_pick[x] = port_pins[p*PINS + x];
      end

      assign irq_line[x] = line_ok[x] & line_pick[x];

      // R5: reserved codes keep the line low
      p_reserved_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code) >= PORTS) |-> !irq_line[x]);

      if (x >= LAST_PINS) begin : g_upper
        // R6: the short port cannot drive upper lines
        p_short_port_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (int'(code) == PORTS - 1) |-> !irq_line[x]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_port_route.sv
module irq_port_route
  import irq_route_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LINES     = 16,
  parameter int PORTS     = 11,
  parameter int PINS      = 16,
  parameter int LAST_PINS = 8,
  parameter int PER_REG   = 4,
  parameter int BASE_OFF  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [PORTS*PINS-1:0] port_pins,
  output logic [LINES-1:0]      irq_line
);
  localparam int REGS = LINES / PER_REG;

  logic [LINES*FIELD_W-1:0] sel_flat;

  irq_sel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGS(REGS),
    .PER_REG(PER_REG), .BASE_OFF(BASE_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_flat(sel_flat)
  );

  irq_line_mux #(
    .LINES(LINES), .PORTS(PORTS), .PINS(PINS), .LAST_PINS(LAST_PINS)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .sel_flat(sel_flat),
    .port_pins(port_pins), .irq_line(irq_line)
  );
endmodule

// File: tb/sim_irq_port_route.sv
module sim_irq_port_route;
  localparam int PORTS = 11;
  localparam int PINS  = 16;
  localparam int LINES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [PORTS*PINS-1:0] port_pins = '0;
  logic [LINES-1:0] irq_line;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R1";
  int    sel_m [LINES];
  logic [31:0] exp_rdata = '0;
  bit    done = 0;

  always #10 clk = ~clk;

  irq_port_route u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_pins(port_pins), .irq_line(irq_line)
  );

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int n;
    logic [31:0] v;
    v = 0;
    if (a >= 12'h008 && a <= 12'h014 && a[1:0] == 2'b00) begin
      n = (int'(a) - 8) / 4;
      for (int k = 0; k < 4; k++) v[4*k +: 4] = 4'(sel_m[4*n + k]);
    end
    return v;
  endfunction

  function automatic logic exp_line(input int x);
    int c;
    c = sel_m[x];
    if (c > 10) return 1'b0;
    if (c == 10 && x >= 8) return 1'b0;
    return port_pins[c*16 + x];
  endfunction

  // Reference model, advanced on each clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (sel_m[i]) sel_m[i] = 0;
      exp_rdata = 0;
    end else if (bus_en && !bus_wr) begin
      exp_rdata = model_read(bus_addr);
    end else if (bus_en && bus_wr) begin
      if (bus_addr >= 12'h008 && bus_addr <= 12'h014 && bus_addr[1:0] == 2'b00)
        for (int k = 0; k < 4; k++)
          sel_m[(int'(bus_addr) - 8) + k] = int'(bus_wdata[4*k +: 4]);
    end
  end

  // Compare every cycle, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      logic [15:0] e;
      for (int x = 0; x < LINES; x++) e[x] = exp_line(x);
      n_checks++;
      if (irq_line !== e) begin
        n_fail++;
        $display("FAIL %s lines actual=%h expected=%h", tag, irq_line, e);
      end
      n_checks++;
      if (bus_rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rdata);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rand_pins(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int w = 0; w < PORTS; w++) port_pins[w*16 +: 16] = 16'($urandom);
    end
  endtask

  task automatic fill_all(input logic [3:0] c);
    for (int n = 0; n < 4; n++) wr(12'(8 + 4*n), {16'h0, {4{c}}});
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    port_pins = {PORTS{16'hA5C3}};
    repeat (3) @(negedge clk);
    rst_n = 1;
    rand_pins(3);
    rd(12'h008);
    rd(12'h014);

    // R4: each legal code on every line
    tag = "R4";
    for (int c = 0; c <= 10; c++) begin
      fill_all(4'(c));
      rand_pins(3);
    end

    // R3: distinct code per line with walking pins
    tag = "R3";
    wr(12'h008, 32'h0000_3210);
    wr(12'h00C, 32'h0000_7654);
    wr(12'h010, 32'h0000_1098);
    wr(12'h014, 32'h0000_5432);
    for (int p = 0; p < PORTS; p++)
      for (int i = 0; i < PINS; i++) begin
        @(negedge clk);
        port_pins = '0;
        port_pins[p*16 + i] = 1'b1;
      end

    // R5: reserved codes with pins all high
    tag = "R5";
    port_pins = '1;
    wr(12'h008, 32'h0000_BCDE);
    wr(12'h00C, 32'h0000_FBCD);
    wr(12'h010, 32'h0000_EFBC);
    wr(12'h014, 32'h0000_DEFB);
    rand_pins(2);
    @(negedge clk) port_pins = '1;
    repeat (2) @(negedge clk);

    // R6: port K on every line
    tag = "R6";
    fill_all(4'hA);
    repeat (2) @(negedge clk);
    rand_pins(4);

    // R7: upper bits ignored
    tag = "R7";
    wr(12'h00C, 32'hABCD_0123);
    rd(12'h00C);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010);

    // R2: stray addresses do not write
    tag = "R2";
    wr(12'h009, 32'h0000_5555);
    wr(12'h004, 32'h0000_5555);
    wr(12'h018, 32'h0000_5555);
    wr(12'h00A, 32'h0000_5555);
    wr(12'h108, 32'h0000_5555);
    rd(12'h008); rd(12'h00C); rd(12'h010); rd(12'h014);
    rand_pins(2);

    // R8: registered read, hold, unmapped reads zero
    tag = "R8";
    rd(12'h014);
    repeat (3) @(negedge clk);
    rd(12'h009);
    rd(12'h000);
    rd(12'h008);
    repeat (2) @(negedge clk);

    // R9: new code effective next cycle, pins pass straight through
    tag = "R9";
    for (int c = 0; c < 11; c++) begin
      wr(12'(8 + 4*(c % 4)), {16'h0, 4'(c), 4'((c+3) % 11), 4'((c+5) % 11), 4'((c+7) % 11)});
      rand_pins(2);
    end

    finish_up();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        finish_up();
      end
    end
  end
endmodule